// File: doc/BRIEF.md
# Call/Return Flow Checker

This block sits beside the commit stage of a five-stage pipelined processor. It follows which function is running from the committed instruction word and program counter. The current function is a state register with one value per function. A sticky trap flag adds one more state, which marks an illegal transfer. Every committed call or return is checked against a matrix of permitted function-to-function calls. Returns must also match a small return stack of callers. Any mismatch moves the checker into the trap and raises `invalid`, which is meant to feed a non-maskable interrupt.

Software loads the permission matrix one row at a time before the application starts. A mode input picks one of two stall policies. In detection mode the processor keeps committing ordinary instructions while a check is in flight. In prevention mode nothing commits until the check is done. The lookup takes one clock cycle: a control instruction accepted at one edge is verified in the next cycle, and its result appears after the edge that follows.

Top module: `callflow_guard`

## Requirements
- R1: While and after a synchronous reset, `invalid` and `stall` are 0, `cur_func` is 0, the return stack is empty and every row of the permission matrix is cleared.
- R2: A committed word is a call when bits [31:26] are 6'b000011 and a return when they are 6'b000100. The destination function ID is in bits [FID_W-1:0]. Any other opcode leaves `cur_func` and `invalid` unchanged. A call or return with any other bit set is malformed and traps.
- R3: A call from function c to function d with matrix bit [c][d] set makes `cur_func` equal d and pushes c. The result is visible after the second rising edge following the commit, and `invalid` stays 0.
- R4: A call whose matrix bit [c][d] is clear traps, and `invalid` is 1 after the second rising edge following the commit.
- R5: A return to function d from function c is legal only when d equals the top of the return stack and matrix bit [d][c] is set. A legal return pops the stack and sets `cur_func` to d. Any other return traps.
- R6: A call or return whose PC, shifted right by REGION_LSB (12), does not equal the current function ID traps.
- R7: A call with DEPTH (8) entries already on the stack traps (overflow). A return with an empty stack traps (underflow).
- R8: The trap is sticky. `invalid` stays 1 and `cur_func` does not change, whatever is committed, until reset. While trapped `stall` stays 0.
- R9: In prevention mode (`mode_prevent`=1), `stall` is 1 for the whole cycle after a call or return is accepted, whether or not a commit is presented.
- R10: In detection mode, `stall` is 1 in that verify cycle only when another call or return is presented. Ordinary instructions commit without a stall.
- R11: A commit presented while `stall` is 1 is ignored. It starts no check and moves no state.
- R12: With `tbl_we`=1, row `tbl_row` of the matrix is overwritten with `tbl_mask`, where bit j of row i permits a call from function i to function j. Rows at or above NFUNC are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_prevent | input | 1 | 1 selects the prevention stall policy, 0 selects detection |
| tbl_we | input | 1 | Permission matrix row write strobe |
| tbl_row | input | FID_W | Row (caller function) being written |
| tbl_mask | input | NFUNC | Permitted callees for that row |
| commit_valid | input | 1 | An instruction commits this cycle |
| commit_instr | input | XLEN | Committed instruction word |
| commit_pc | input | XLEN | Committed instruction address |
| stall | output | 1 | Hold the commit stage |
| invalid | output | 1 | Illegal transfer seen (sticky) |
| cur_func | output | FID_W | Function currently executing |

## Verification
A call or return presented before rising edge E1 is held in a pending register at E1. It is verified in the cycle between E1 and E2, and it updates `cur_func`, the stack and `invalid` at E2. The bench therefore drives each commit on a falling edge and reads `stall` just after the next falling edge, which falls inside the verify cycle. It reads `cur_func` and `invalid` one falling edge later. Tests of ignored commits hold the bench for two extra cycles and then check that `cur_func` still shows the first result.

// File: rtl/callflow_guard.sv
module callflow_guard #(
  parameter int NFUNC      = 4,
  parameter int DEPTH      = 8,
  parameter int XLEN       = 32,
  parameter int REGION_LSB = 12,
  parameter logic [5:0] OP_CALL = 6'h03,
  parameter logic [5:0] OP_RET  = 6'h04,
  localparam int FID_W = (NFUNC > 1) ? $clog2(NFUNC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_prevent,
  input  logic             tbl_we,
  input  logic [FID_W-1:0] tbl_row,
  input  logic [NFUNC-1:0] tbl_mask,
  input  logic             commit_valid,
  input  logic [XLEN-1:0]  commit_instr,
  input  logic [XLEN-1:0]  commit_pc,
  output logic             stall,
  output logic             invalid,
  output logic [FID_W-1:0] cur_func
);
  localparam int SP_W = $clog2(DEPTH + 1);
  localparam int IX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [FID_W:0] NF = NFUNC[FID_W:0];
  localparam logic [SP_W-1:0] FULL = DEPTH[SP_W-1:0];
  localparam logic [XLEN-1:0] KEEP =
    {6'h3f, {(XLEN-6){1'b0}}} | {{(XLEN-FID_W){1'b0}}, {FID_W{1'b1}}};

  logic [NFUNC-1:0] allow [NFUNC];
  logic [FID_W-1:0] stack [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [FID_W-1:0] cur;
  logic             trap;

  logic             pend_v, pend_call, pend_ok;
  logic [FID_W-1:0] pend_dst;

  wire [5:0] opcode  = commit_instr[XLEN-1 -: 6];
  wire       is_call = opcode == OP_CALL;
  wire       is_ret  = opcode == OP_RET;
  wire       is_ctrl = is_call | is_ret;
  wire       well    = (commit_instr & ~KEEP) == '0;
  wire       pc_ok   = (commit_pc >> REGION_LSB) == XLEN'(cur);

  assign stall = pend_v & (mode_prevent | (commit_valid & is_ctrl));
  wire accept = commit_valid & is_ctrl & ~stall & ~trap;

  wire [SP_W-1:0]  top_sp = sp - 1'b1;
  wire [FID_W-1:0] top    = stack[top_sp[IX_W-1:0]];
  wire dst_ok  = {1'b0, pend_dst} < NF;
  wire call_ok = allow[cur][pend_dst] & (sp < FULL);
  wire ret_ok  = (sp != '0) & (top == pend_dst) & allow[pend_dst][cur];
  wire pass    = pend_ok & dst_ok & (pend_call ? call_ok : ret_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NFUNC; i++) allow[i] <= '0;
    end else if (tbl_we && ({1'b0, tbl_row} < NF)) begin
      allow[tbl_row] <= tbl_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_call <= 1'b0;
      pend_ok   <= 1'b0;
      pend_dst  <= '0;
    end else begin
      pend_v <= accept;
      if (accept) begin
        pend_call <= is_call;
        pend_ok   <= well & pc_ok;
        pend_dst  <= commit_instr[FID_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      sp   <= '0;
      trap <= 1'b0;
      for (int i = 0; i < DEPTH; i++) stack[i] <= '0;
    end else if (pend_v && !trap) begin
      if (!pass) begin
        trap <= 1'b1;
      end else begin
        cur <= pend_dst;
        if (pend_call) begin
          stack[sp[IX_W-1:0]] <= cur;
          sp <= sp + 1'b1;
        end else begin
          sp <= top_sp;
        end
      end
    end
  end

  assign invalid  = trap;
  assign cur_func = cur;

  p_stack_bound_r7: assert property (@(posedge clk) disable iff (rst) sp <= FULL);
  p_trap_sticky_r8: assert property (@(posedge clk) disable iff (rst) invalid |=> invalid);
  p_frozen_r8: assert property (@(posedge clk) disable iff (rst) invalid |=> $stable(cur_func));
  p_idle_keeps_r2: assert property (@(posedge clk) disable iff (rst) !pend_v |=> $stable(cur_func));
  p_rise_after_check_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(invalid) |-> $past(pend_v));
  p_prev_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_prevent && accept) |=> (stall || !mode_prevent));
  p_det_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (!mode_prevent && stall) |-> (commit_valid && is_ctrl));
  p_trap_no_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (invalid && $past(invalid)) |-> !stall);
endmodule

// File: tb/callflow_guard_tb.sv
module callflow_guard_tb_top;
  localparam int CLK_P = 10;
  localparam logic [5:0] OPC = 6'h03, OPR = 6'h04, OPX = 6'h08;

  logic clk = 0, rst = 1, mode_prevent = 0, tbl_we = 0, commit_valid = 0;
  logic [1:0] tbl_row = 0;
  logic [3:0] tbl_mask = 0;
  logic [31:0] commit_instr = 0, commit_pc = 0;
  logic stall, invalid;
  logic [1:0] cur_func;
  int checks = 0, fails = 0;
  logic st_seen;

  always #(CLK_P/2) clk = ~clk;

  callflow_guard dut_i (.clk, .rst, .mode_prevent, .tbl_we, .tbl_row, .tbl_mask,
    .commit_valid, .commit_instr, .commit_pc, .stall, .invalid, .cur_func);

  // {kind(0 other,1 call,2 ret), dst, pc region, expected cur_func}
  localparam logic [7:0] VEC [9] = '{
    {2'd1,2'd1,2'd0,2'd1}, {2'd0,2'd0,2'd1,2'd1}, {2'd1,2'd2,2'd1,2'd2},
    {2'd1,2'd3,2'd2,2'd3}, {2'd2,2'd2,2'd3,2'd2}, {2'd2,2'd1,2'd2,2'd1},
    {2'd2,2'd0,2'd1,2'd0}, {2'd1,2'd2,2'd0,2'd2}, {2'd2,2'd0,2'd2,2'd0}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(logic [5:0] op, logic [1:0] d);
    return {op, 24'h0, d};
  endfunction

  task automatic load_row(logic [1:0] r, logic [3:0] m);
    @(negedge clk); tbl_we = 1; tbl_row = r; tbl_mask = m;
    @(negedge clk); tbl_we = 0;
  endtask

  task automatic do_reset(bit load);
    @(negedge clk); rst = 1; commit_valid = 0;
    @(negedge clk); rst = 0;
    if (load) begin
      load_row(0, 4'b0111); load_row(1, 4'b0100);
      load_row(2, 4'b1000); load_row(3, 4'b0000);
    end
  endtask

  // present at a falling edge, stall sampled in verify cycle, result one cycle later
  task automatic issue(logic [31:0] ins, logic [1:0] region);
    @(negedge clk); commit_valid = 1; commit_instr = ins; commit_pc = {18'h0, region, 12'h0};
    @(negedge clk); commit_valid = 0; #1 st_seen = stall;
    @(negedge clk); #1;
  endtask

  initial begin
    #(CLK_P*20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 invalid in reset", invalid, 0);
    check("R1 stall in reset", stall, 0);
    check("R1 cur_func in reset", cur_func, 0);
    do_reset(0); #1;
    check("R1 cur_func after reset", cur_func, 0);
    // R12: empty matrix after reset, any call traps
    issue(word(OPC, 1), 0);
    check("R12 empty table call traps", invalid, 1);
    issue(word(OPC, 1), 0);
    check("R8 still invalid", invalid, 1);
    check("R8 no stall when trapped", st_seen, 0);
    check("R8 cur frozen", cur_func, 0);

    do_reset(1); #1;
    check("R8 reset clears trap", invalid, 0);
    foreach (VEC[i]) begin
      logic [31:0] w;
      w = VEC[i][7:6] == 1 ? word(OPC, VEC[i][5:4]) :
          VEC[i][7:6] == 2 ? word(OPR, VEC[i][5:4]) : word(OPX, VEC[i][5:4]);
      issue(w, VEC[i][3:2]);
      check("R3/R5/R2 vector cur_func", cur_func, VEC[i][1:0]);
      check("R3/R5 vector invalid", invalid, 0);
      check("R10 lone check no stall", st_seen, 0);
    end

    // R10 / R11 in detection mode
    do_reset(1);
    issue(word(OPC, 1), 0);
    @(negedge clk); commit_valid = 1; commit_instr = word(OPC, 2); commit_pc = 32'h1000;
    @(negedge clk); commit_valid = 1; commit_instr = word(OPX, 0); commit_pc = 32'h2000;
    #1 check("R10 ordinary commit not stalled", stall, 0);
    @(negedge clk); commit_valid = 1; commit_instr = word(OPC, 3); commit_pc = 32'h2000;
    @(negedge clk); commit_valid = 1; commit_instr = word(OPC, 3); commit_pc = 32'h2000;
    #1 check("R10 second control stalled", stall, 1);
    @(negedge clk); commit_valid = 0;
    repeat (2) @(negedge clk); #1;
    check("R11 stalled control ignored", cur_func, 3);
    check("R11 no trap", invalid, 0);

    // R9 prevention mode with ignored stalled commit
    do_reset(1); mode_prevent = 1;
    @(negedge clk); commit_valid = 1; commit_instr = word(OPC, 1); commit_pc = 0;
    @(negedge clk); commit_valid = 1; commit_instr = word(OPX, 0); commit_pc = 32'h1000;
    #1 check("R9 prevention stalls ordinary commit", stall, 1);
    @(negedge clk); commit_valid = 0; #1;
    check("R9 stall released", stall, 0);
    check("R3 call landed", cur_func, 1);
    issue(word(OPC, 2), 1);
    check("R9 stall in verify cycle", st_seen, 1);
    check("R11 prevention cur", cur_func, 2);
    mode_prevent = 0;

    do_reset(1);
    issue(word(OPC, 3), 0);
    check("R4 forbidden call traps", invalid, 1);

    do_reset(1);
    issue(word(OPC, 1), 0);
    issue(word(OPR, 2), 1);
    check("R5 wrong return target traps", invalid, 1);

    do_reset(1);
    issue(word(OPR, 0), 0);
    check("R7 underflow traps", invalid, 1);

    do_reset(1);
    issue(word(OPC, 1), 2);
    check("R6 pc region mismatch traps", invalid, 1);

    do_reset(1);
    issue(word(OPC, 1) | 32'h400, 0);
    check("R2 malformed call traps", invalid, 1);

    do_reset(1);
    for (int k = 0; k < 8; k++) issue(word(OPC, 0), 0);
    check("R7 eight nested calls legal", invalid, 0);
    issue(word(OPC, 0), 0);
    check("R7 overflow traps", invalid, 1);
    issue(word(OPC, 1), 0);
    check("R8 trap survives legal call", invalid, 1);
    check("R8 cur frozen after trap", cur_func, 0);
    do_reset(1); #1;
    check("R1 reset clears", invalid, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule